// File: doc/BRIEF.md
# Output Driver Impedance Trim Sequencer

This block keeps a 5-bit trim code for an output driver whose strength comes in 32 binary-weighted steps. An analog comparator, outside the block, reports which way the driver impedance should move. Every 64 clock cycles the block samples that direction and moves its working code by at most one step. The working code saturates at both ends of the range.

The drivers must never change strength while they drive the line. For this reason the working code is copied into the applied code only on a clock edge where the output-high-Z status goes from low to high. A write or a deselect produces that edge.

A power-up tracker counts clock cycles from reset. It raises a calibration-done flag at the first low-to-high high-Z transition seen after 2048 cycles have elapsed. The flag then stays high until the next reset.

Top module: `drv_trim_seq`

## Requirements
- R1: While reset is active and right after it, the working code and the applied code both equal 16 and the done flag is 0.
- R2: The working code can change only on clock edges numbered 64, 128, 192 and so on, counted from the first edge after reset release.
- R3: On an evaluation edge, direction 2'b01 (raise) adds one to the working code. A code of 31 stays at 31.
- R4: On an evaluation edge, direction 2'b10 (lower) subtracts one from the working code. A code of 0 stays at 0.
- R5: Direction 2'b00 (match) leaves the working code unchanged. So does direction 2'b11.
- R6: On an edge where the high-Z input is 1 and was 0 on the previous edge, the applied code takes the working code value held just before that edge. On every other edge the applied code holds.
- R7: A high-Z input that is already 1 at reset release does not count as a low-to-high transition.
- R8: The done flag rises only on a low-to-high high-Z edge taken after at least 2048 edges have elapsed since reset release. Such an edge at or before edge 2048 leaves it at 0.
- R9: Once set, the done flag stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cmp_dir_i | input | 2 | Comparator direction: 01 raise, 10 lower, 00/11 match |
| hiz_i | input | 1 | Output driver is in high impedance |
| applied_code_o | output | 5 | Code currently driving the output stage |
| work_code_o | output | 5 | Working code moved by the evaluations |
| cal_done_o | output | 1 | Power-up calibration complete |

## Verification
The direction input is held at raise long enough for the code to climb to 31 and sit there. It is then held at lower until the code reaches 0, then at both match encodings, then varied on every evaluation. These runs tell apart stepping, saturation at each end, and holding. Meanwhile the high-Z input toggles with a period that is not a multiple of 64, and in one stretch it stays high. This shows that the applied code follows only on low-to-high edges, and not on levels or on evaluations. The first high-Z rise comes well before cycle 2048, so the bench can tell an early done flag from one that correctly waits for the count and the next transition.

// File: rtl/dts_pkg.sv
package dts_pkg;
    parameter int CODE_W = 5;
    parameter int EVAL_PERIOD = 64;
    parameter int SETTLE_CYCLES = 2048;

    typedef enum logic [1:0] {
        DIR_HOLD     = 2'b00,
        DIR_UP       = 2'b01,
        DIR_DOWN     = 2'b10,
        DIR_HOLD_ALT = 2'b11
    } dir_e;
endpackage

// File: rtl/dts_tick.sv
module dts_tick #(
    parameter int PERIOD = 64
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic tick_o
);
    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) st_d.cnt = '0;
        else                  st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign tick_o = (st_q.cnt == LAST);

    // R2: ticks are never back to back when the period exceeds one
    p_tick_spaced_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (PERIOD > 1) && tick_o |=> !tick_o);
endmodule

// File: rtl/dts_step.sv
module dts_step
    import dts_pkg::*;
#(
    parameter int W = 5,
    parameter int START = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         tick_i,
    input  dir_e         dir_i,
    output logic [W-1:0] code_o
);
    localparam logic [W-1:0] TOP   = {W{1'b1}};
    localparam logic [W-1:0] INIT  = W'(START);

    typedef struct packed {
        logic [W-1:0] code;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick_i) begin
            case (dir_i)
                DIR_UP:   if (st_q.code != TOP) st_d.code = st_q.code + 1'b1;
                DIR_DOWN: if (st_q.code != '0)  st_d.code = st_q.code - 1'b1;
                default:  st_d.code = st_q.code;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q.code <= INIT;
        else         st_q <= st_d;
    end

    assign code_o = st_q.code;

    // R2: a change of the code needs an evaluation tick on the previous edge
    p_only_on_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (code_o != $past(code_o)) |-> $past(tick_i));
    // R3: no wrap past the top
    p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(code_o) == TOP) && $past(dir_i == DIR_UP) |-> code_o == TOP);
    // R4: no wrap below zero
    p_no_underflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(code_o) == '0) && $past(dir_i == DIR_DOWN) |-> code_o == '0);
    // R5: match encodings hold the code
    p_match_holds_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(dir_i == DIR_HOLD || dir_i == DIR_HOLD_ALT) |-> $stable(code_o));
endmodule

// File: rtl/dts_settle.sv
module dts_settle #(
    parameter int CYCLES = 2048
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic rise_i,
    output logic done_o
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(CYCLES);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          done;
    } st_t;

    st_t  st_d, st_q;
    logic elapsed;

    assign elapsed = (st_q.cnt == LIMIT);

    always_comb begin
        st_d = st_q;
        if (!elapsed) st_d.cnt = st_q.cnt + 1'b1;
        if (elapsed && rise_i) st_d.done = 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign done_o = st_q.done;

    // R8: done rises only after the count has run out and a rise was seen
    p_done_needs_count_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(done_o) |-> $past(elapsed) && $past(rise_i));
    // R9: done is sticky
    p_done_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(done_o) |-> done_o);
endmodule

// File: rtl/drv_trim_seq.sv
module drv_trim_seq (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [1:0] cmp_dir_i,
    input  logic       hiz_i,
    output logic [4:0] applied_code_o,
    output logic [4:0] work_code_o,
    output logic       cal_done_o
);
    import dts_pkg::*;

    localparam int START = 1 << (CODE_W - 1);

    typedef struct packed {
        logic              hiz_prev;
        logic [CODE_W-1:0] applied;
    } st_t;

    st_t  st_d, st_q;
    logic tick;
    logic hiz_rise;
    logic [CODE_W-1:0] work;

    dts_tick #(.PERIOD(EVAL_PERIOD)) u_tick (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_o (tick)
    );

    dts_step #(.W(CODE_W), .START(START)) u_step (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_i (tick),
        .dir_i  (dir_e'(cmp_dir_i)),
        .code_o (work)
    );

    assign hiz_rise = hiz_i & ~st_q.hiz_prev;

    dts_settle #(.CYCLES(SETTLE_CYCLES)) u_settle (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .rise_i (hiz_rise),
        .done_o (cal_done_o)
    );

    always_comb begin
        st_d = st_q;
        st_d.hiz_prev = hiz_i;
        if (hiz_rise) st_d.applied = work;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.hiz_prev <= 1'b1;
            st_q.applied  <= CODE_W'(START);
        end else begin
            st_q <= st_d;
        end
    end

    assign applied_code_o = st_q.applied;
    assign work_code_o    = work;

    // R6: the applied code holds unless a low-to-high high-Z edge occurred
    p_applied_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(hiz_rise) |-> $stable(applied_code_o));
    // R6: at a rise the applied code picks up the prior working code
    p_applied_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(hiz_rise) |-> applied_code_o == $past(work_code_o));
endmodule

// File: tb/tb_drv_trim_seq.sv
module tb_drv_trim_seq;
    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic [1:0] cmp_dir_i = 2'b00;
    logic       hiz_i = 1'b1;
    logic [4:0] applied_code_o;
    logic [4:0] work_code_o;
    logic       cal_done_o;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    int m_work = 16, m_app = 16, m_done = 0, m_prev = 1, e = 0;

    always #5 clk_i = ~clk_i;

    drv_trim_seq dut (.*);

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s at edge %0d: actual %0d expected %0d", tag, e, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // Behavioural reference: edge number e counted from reset release
    task automatic step_model();
        bit rise;
        e++;
        rise = (hiz_i == 1'b1) && (m_prev == 0);
        if (rise) begin
            m_app = m_work;
            if (e - 1 >= 2048) m_done = 1;
        end
        if (e % 64 == 0) begin
            if (cmp_dir_i == 2'b01 && m_work < 31) m_work++;
            else if (cmp_dir_i == 2'b10 && m_work > 0) m_work--;
        end
        m_prev = hiz_i;
    endtask

    task automatic run(input int n, input int mode);
        for (int i = 0; i < n; i++) begin
            case (mode)
                0: cmp_dir_i = 2'b01;
                1: cmp_dir_i = 2'b10;
                2: cmp_dir_i = ((e / 64) % 2 == 0) ? 2'b00 : 2'b11;
                default: cmp_dir_i = 2'((e / 64) % 3);
            endcase
            if (e > 4600 && e < 4800) hiz_i = 1'b1;
            else hiz_i = ((e / 37) % 2 == 1);
            @(posedge clk_i);
            step_model();
            @(negedge clk_i);
            check("R2 working code", work_code_o, m_work);
            check("R6 applied code", applied_code_o, m_app);
            check("R9 done flag", cal_done_o, m_done);
            if (e == 2040) check("R8 done before 2048", cal_done_o, 0);
        end
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk_i);
        @(negedge clk_i);
        check("R1 working at reset", work_code_o, 16);
        check("R1 applied at reset", applied_code_o, 16);
        check("R1 done at reset", cal_done_o, 0);
        rst_ni = 1'b1;
        // R7: hiz held high across release must not load or count
        for (int i = 0; i < 20; i++) begin
            @(posedge clk_i);
            step_model();
            @(negedge clk_i);
        end
        check("R7 applied after release", applied_code_o, 16);
        run(64 * 20 - 20, 0);
        check("R3 saturate high", work_code_o, 31);
        run(64 * 36, 1);
        check("R4 saturate low", work_code_o, 0);
        check("R8 done after count and rise", cal_done_o, 1);
        run(64 * 2, 0);
        check("R3 step up", work_code_o, 2);
        run(64 * 6, 2);
        check("R5 match holds", work_code_o, 2);
        run(64 * 20, 3);
        summary();
    end
endmodule